// File: doc/BRIEF.md
# Two-Word Masked Trigger Sequencer

The block samples a 28-bit vector of pin states on every clock and raises a trigger after two pattern words have matched in a fixed order. Each word has an expected-value register and a qualifier register. A qualifier bit of 1 means that pin is compared against the expected value. A qualifier bit of 0 makes that pin a don't-care. Word 2 is armed only after word 1 has been seen, so the trigger marks a sequence of two events and not a single pattern.

The four pattern and qualifier registers are written through one serial port. Bits are shifted MSB first into a staging register. A load strobe then copies the staged word into the register chosen by a 2-bit select, so the comparators never see a word that is only partly shifted in. A controller supplies three enables: one for word-1 evaluation, one for word-2 evaluation, and one for the trigger pulse. It also supplies a synchronous flag clear and a start-of-test input. The outputs are two sticky status flags and a one-clock trigger pulse.

Top module: `trig_seq`

## Requirements
- R1: After a synchronous reset, `seen1_o`, `seen2_o` and `trig_o` are 0. All four pattern and qualifier registers are 0, which makes every pin a don't-care.
- R2: In each clock with `shift_en_i` high, the staging register shifts left by one and takes `sdi_i` into bit 0. After 28 shifts, the first bit sent sits in bit 27 (MSB first).
- R3: A clock with `load_i` high copies the staging register into the register addressed by `sel_i`. The codes are 0 = word-1 data, 1 = word-1 qualifier, 2 = word-2 data and 3 = word-2 qualifier. The other three registers are unchanged. Shifting without a load changes none of the four registers.
- R4: A word matches when, for every bit whose qualifier is 1, the pin equals the data bit. Bits whose qualifier is 0 are ignored.
- R5: When `en_w1_i` is high and word 1 matches at a clock edge, `seen1_o` is 1 from that edge on.
- R6: Word 2 is evaluated only when `seen1_o` is already 1. A word-2 match in an earlier cycle, or in the same cycle as the first word-1 match, does not set `seen2_o`.
- R7: When `seen1_o` is 1, `en_w2_i` is high and word 2 matches, `seen2_o` becomes 1 at that edge. `trig_o` is then high for exactly that one cycle, even if the pins keep matching.
- R8: If `en_trig_i` is low when the word-2 event occurs, `seen2_o` still sets but `trig_o` stays 0.
- R9: The flags hold their value until `clr_i` or `start_i` is high at an edge. Either input clears both flags and `trig_o`, and it overrides a match in the same cycle.
- R10: With `en_w1_i` low, word 1 cannot set `seen1_o`. With `en_w2_i` low, word 2 cannot set `seen2_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 28 | Sampled pin states |
| sdi_i | input | 1 | Serial data into the staging register |
| shift_en_i | input | 1 | Shift one bit into the staging register |
| load_i | input | 1 | Copy the staged word into the selected register |
| sel_i | input | 2 | Destination: 0 w1 data, 1 w1 qualifier, 2 w2 data, 3 w2 qualifier |
| en_w1_i | input | 1 | Enable word-1 evaluation |
| en_w2_i | input | 1 | Enable word-2 evaluation |
| en_trig_i | input | 1 | Enable the trigger pulse |
| clr_i | input | 1 | Synchronous clear of the flags |
| start_i | input | 1 | Start of test; clears the flags |
| seen1_o | output | 1 | Sticky: word 1 has occurred |
| seen2_o | output | 1 | Sticky: word 2 has occurred after word 1 |
| trig_o | output | 1 | One-clock trigger pulse |

## Verification
The hardest case to reach is a pin vector that satisfies word 1 and word 2 in the same cycle while word 1 has not yet been seen. The ordering rule must then hold back `seen2_o` for one cycle. The bench sets up this case by loading an all-zero qualifier for word 2, so that word 2 matches every vector. It then presents the word-1 pattern and checks that `seen2_o` and `trig_o` appear one cycle after `seen1_o` and not together with it. A trigger that is suppressed while `seen2_o` still sets is reached by holding the trigger enable low through a full two-word sequence.

// File: rtl/trig_seq_pkg.sv
// Package: shared constants and the register select encoding.
// Assumes a 2-bit select that addresses four pattern/qualifier registers.
package trig_seq_pkg;
    localparam int unsigned PIN_COUNT = 28;
    localparam int unsigned SEL_BITS  = 2;
    localparam int unsigned WORDS     = 2;

    typedef enum logic [SEL_BITS-1:0] {
        SEL_W1_DATA = 2'd0,
        SEL_W1_QUAL = 2'd1,
        SEL_W2_DATA = 2'd2,
        SEL_W2_QUAL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/trig_shift_loader.sv
// Module: serial staging register plus the four pattern/qualifier registers.
// Bits enter MSB first. A load strobe copies the staged word into the register
// named by sel_i (data of word k at index 2k, qualifier at 2k+1).
// Assumes shift and load are not needed in the same cycle; shift_en_i and
// load_i act independently when both are high.
module trig_shift_loader #(
    parameter int unsigned W     = 28,
    parameter int unsigned SEL_W = 2,
    parameter int unsigned NWORD = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sdi_i,
    input  logic                        shift_en_i,
    input  logic                        load_i,
    input  logic [SEL_W-1:0]            sel_i,
    output logic [NWORD-1:0][W-1:0]     data_o,
    output logic [NWORD-1:0][W-1:0]     qual_o
);
    localparam int unsigned NREG = 2 * NWORD;

    logic [W-1:0]            stage_q;
    logic [NREG-1:0][W-1:0]  regs_q;

    // Staging register: shift left, new bit into the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n)          stage_q <= '0;
        else if (shift_en_i) stage_q <= {stage_q[W-2:0], sdi_i};
    end

    // Register bank: copy the staged word into the selected entry on load.
    always_ff @(posedge clk) begin
        if (!rst_n)       regs_q <= '0;
        else if (load_i)  regs_q[sel_i] <= stage_q;
    end

    // Split the bank into per-word data and qualifier views.
    for (genvar k = 0; k < NWORD; k++) begin : g_view
        assign data_o[k] = regs_q[2*k];
        assign qual_o[k] = regs_q[2*k+1];
    end

    // R2: the bit shifted in appears at the LSB one cycle later.
    assert_shift_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> (stage_q[0] == $past(sdi_i)));

    // R2: the rest of the word moves up by one position.
    assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> (stage_q[W-1:1] == $past(stage_q[W-2:0])));

    // R3: without a load strobe the register bank holds.
    assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(regs_q));
endmodule

// File: rtl/trig_word_match.sv
// Module: masked comparison of the pin vector against one trigger word.
// Per bit, a qualifier of 1 compares the pin with the data bit and a qualifier
// of 0 makes the pin a don't-care. Purely combinational.
module trig_word_match #(
    parameter int unsigned W = 28
) (
    input  logic [W-1:0] pins_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] qual_i,
    output logic         match_o
);
    logic [W-1:0] bit_ok;

    // Per-pin acceptance: equal to expected value, or masked off.
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign bit_ok[b] = ~(pins_i[b] ^ data_i[b]) | ~qual_i[b];
    end

    // Word matches only when every pin is accepted.
    always_comb match_o = &bit_ok;
endmodule

// File: rtl/trig_seq_ctrl.sv
// Module: ordering state for the two words.
// Holds sticky seen flags and produces a one-cycle trigger pulse. Word 2 is
// considered only after the registered word-1 flag is set. Clear and
// start-of-test have priority over any match in the same cycle.
module trig_seq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic match1_i,
    input  logic match2_i,
    input  logic en_w1_i,
    input  logic en_w2_i,
    input  logic en_trig_i,
    input  logic clr_i,
    input  logic start_i,
    output logic seen1_o,
    output logic seen2_o,
    output logic trig_o
);
    logic wipe;
    logic hit1;
    logic hit2;

    // Event decode: wipe request, first-word hit, armed second-word hit.
    always_comb begin
        wipe = clr_i | start_i;
        hit1 = en_w1_i & match1_i & ~seen1_o;
        hit2 = en_w2_i & match2_i & seen1_o & ~seen2_o;
    end

    // Word-1 sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) seen1_o <= 1'b0;
        else if (hit1)      seen1_o <= 1'b1;
    end

    // Word-2 sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) seen2_o <= 1'b0;
        else if (hit2)      seen2_o <= 1'b1;
    end

    // Trigger pulse: one cycle on the word-2 event when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) trig_o <= 1'b0;
        else                trig_o <= hit2 & en_trig_i;
    end

    // R6: seen2 can only rise when seen1 was already set.
    assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen2_o) |-> $past(seen1_o));

    // R7: the trigger never lasts beyond one cycle.
    assert_trig_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R7: the trigger coincides with the rise of seen2.
    assert_trig_with_seen2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $rose(seen2_o));

    // R9: clear or start empties every output on the next cycle.
    assert_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i || start_i) |=> (!seen1_o && !seen2_o && !trig_o));

    // R9: seen1 is sticky when no wipe is requested.
    assert_sticky1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen1_o && !clr_i && !start_i) |=> seen1_o);

    // R10: seen1 cannot rise while word-1 evaluation is disabled.
    assert_en1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w1_i |=> !$rose(seen1_o));
endmodule

// File: rtl/trig_seq.sv
// Module: top of the two-word masked trigger sequencer.
// Ties the serial loader, one comparator per word and the ordering control
// together. Assumes pins_i is already synchronous to clk.
module trig_seq
    import trig_seq_pkg::*;
#(
    parameter int unsigned PINS = PIN_COUNT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PINS-1:0]     pins_i,
    input  logic                sdi_i,
    input  logic                shift_en_i,
    input  logic                load_i,
    input  logic [SEL_BITS-1:0] sel_i,
    input  logic                en_w1_i,
    input  logic                en_w2_i,
    input  logic                en_trig_i,
    input  logic                clr_i,
    input  logic                start_i,
    output logic                seen1_o,
    output logic                seen2_o,
    output logic                trig_o
);
    logic [WORDS-1:0][PINS-1:0] data_w;
    logic [WORDS-1:0][PINS-1:0] qual_w;
    logic [WORDS-1:0]           match_w;

    trig_shift_loader #(.W(PINS), .SEL_W(SEL_BITS), .NWORD(WORDS)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdi_i      (sdi_i),
        .shift_en_i (shift_en_i),
        .load_i     (load_i),
        .sel_i      (sel_i),
        .data_o     (data_w),
        .qual_o     (qual_w)
    );

    // One comparator per trigger word.
    for (genvar k = 0; k < WORDS; k++) begin : g_cmp
        trig_word_match #(.W(PINS)) u_match (
            .pins_i  (pins_i),
            .data_i  (data_w[k]),
            .qual_i  (qual_w[k]),
            .match_o (match_w[k])
        );
    end

    trig_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .match1_i  (match_w[0]),
        .match2_i  (match_w[1]),
        .en_w1_i   (en_w1_i),
        .en_w2_i   (en_w2_i),
        .en_trig_i (en_trig_i),
        .clr_i     (clr_i),
        .start_i   (start_i),
        .seen1_o   (seen1_o),
        .seen2_o   (seen2_o),
        .trig_o    (trig_o)
    );

    // R1: out of reset all status outputs are low.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!seen1_o && !seen2_o && !trig_o));
endmodule

// File: tb/trig_seq_bench.sv
`timescale 1ns/1ps
module trig_seq_bench;
    localparam int W = 28;
    localparam logic [W-1:0] PAT_A = 28'h9A5_C31E;
    localparam logic [W-1:0] PAT_B = 28'h1234_567;
    localparam logic [W-1:0] ONES  = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pins = '0;
    logic         sdi = 1'b0, shift_en = 1'b0, load = 1'b0;
    logic [1:0]   sel = 2'd0;
    logic         en_w1 = 1'b0, en_w2 = 1'b0, en_trig = 1'b0;
    logic         clr = 1'b0, start = 1'b0;
    logic         seen1, seen2, trig;
    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    trig_seq u_trig_seq (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .sdi_i(sdi),
        .shift_en_i(shift_en), .load_i(load), .sel_i(sel),
        .en_w1_i(en_w1), .en_w2_i(en_w2), .en_trig_i(en_trig),
        .clr_i(clr), .start_i(start),
        .seen1_o(seen1), .seen2_o(seen2), .trig_o(trig)
    );

    task automatic chk(input bit got, input bit exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    // One clock: inputs were set at a negedge, outputs sampled at the next.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Shift a word MSB first, then load it into register rsel.
    task automatic put_word(input logic [1:0] rsel, input logic [W-1:0] v);
        for (int i = W - 1; i >= 0; i--) begin
            shift_en = 1'b1; sdi = v[i];
            step();
        end
        shift_en = 1'b0; sdi = 1'b0;
        load = 1'b1; sel = rsel;
        step();
        load = 1'b0;
    endtask

    task automatic wipe();
        clr = 1'b1; step(); clr = 1'b0;
    endtask

    task automatic t_reset();
        chk(seen1, 1'b0, "R1 seen1 after reset");
        chk(seen2, 1'b0, "R1 seen2 after reset");
        chk(trig,  1'b0, "R1 trig after reset");
        // All-zero qualifiers: word 1 matches any vector.
        pins = PAT_B; en_w1 = 1'b1; step();
        chk(seen1, 1'b1, "R1 zero qualifier matches anything");
        en_w1 = 1'b0; wipe();
    endtask

    task automatic t_load_and_match();
        put_word(2'd0, PAT_A);
        put_word(2'd1, ONES);
        put_word(2'd2, PAT_B);
        put_word(2'd3, ONES);
        // Shift a junk word with no load: no register may change (R3).
        for (int i = 0; i < W; i++) begin
            shift_en = 1'b1; sdi = i[0]; step();
        end
        shift_en = 1'b0;
        wipe();
        en_w1 = 1'b1;
        pins = PAT_A ^ 28'h1; step();
        chk(seen1, 1'b0, "R4 compared bit differs, no match");
        pins = PAT_A; step();
        chk(seen1, 1'b1, "R2 R3 R5 MSB-first word 1 matches");
        en_w1 = 1'b0; wipe();
        // Mask the low byte of word 1: differences there are ignored.
        put_word(2'd1, ONES ^ 28'hFF);
        en_w1 = 1'b1; pins = PAT_A ^ 28'h5A; step();
        chk(seen1, 1'b1, "R4 masked bits are don't-care");
        en_w1 = 1'b0; wipe();
        en_w1 = 1'b1; pins = PAT_A ^ 28'h100; step();
        chk(seen1, 1'b0, "R4 unmasked bit still compared");
        en_w1 = 1'b0;
        put_word(2'd1, ONES);
        wipe();
    endtask

    task automatic t_order();
        en_w1 = 1'b1; en_w2 = 1'b1; en_trig = 1'b1;
        pins = PAT_B; step();
        chk(seen2, 1'b0, "R6 word 2 before word 1 ignored");
        chk(trig,  1'b0, "R6 no trig before word 1");
        pins = PAT_A; step();
        chk(seen1, 1'b1, "R5 word 1 seen");
        chk(seen2, 1'b0, "R6 seen2 still low");
        pins = PAT_B; step();
        chk(seen2, 1'b1, "R7 seen2 sets");
        chk(trig,  1'b1, "R7 trig pulses");
        step();
        chk(trig,  1'b0, "R7 trig lasts one cycle");
        chk(seen2, 1'b1, "R9 seen2 sticky");
        pins = '0; step();
        chk(seen1, 1'b1, "R9 seen1 sticky");
        wipe();
        chk(seen1, 1'b0, "R9 clear drops seen1");
        chk(seen2, 1'b0, "R9 clear drops seen2");
    endtask

    task automatic t_same_cycle();
        put_word(2'd3, '0);   // word 2 now matches every vector
        wipe();
        pins = PAT_A; step();
        chk(seen1, 1'b1, "R6 same-cycle: seen1 set");
        chk(seen2, 1'b0, "R6 same-cycle: seen2 held back");
        chk(trig,  1'b0, "R6 same-cycle: no trig yet");
        step();
        chk(seen2, 1'b1, "R6 same-cycle: seen2 one cycle later");
        chk(trig,  1'b1, "R7 same-cycle: trig one cycle later");
        put_word(2'd3, ONES);
        wipe();
    endtask

    task automatic t_trig_disabled();
        en_trig = 1'b0;
        pins = PAT_A; step();
        pins = PAT_B; step();
        chk(seen2, 1'b1, "R8 seen2 sets with trigger disabled");
        chk(trig,  1'b0, "R8 no pulse with trigger disabled");
        step();
        chk(trig,  1'b0, "R8 no late pulse");
        en_trig = 1'b1; wipe();
    endtask

    task automatic t_enables();
        en_w1 = 1'b0; pins = PAT_A; step();
        chk(seen1, 1'b0, "R10 word 1 disabled");
        en_w1 = 1'b1; en_w2 = 1'b0; step();
        chk(seen1, 1'b1, "R10 word 1 enabled");
        pins = PAT_B; step();
        chk(seen2, 1'b0, "R10 word 2 disabled");
        en_w2 = 1'b1; step();
        chk(seen2, 1'b1, "R10 word 2 enabled");
        wipe();
    endtask

    task automatic t_clear_priority();
        pins = PAT_A; clr = 1'b1; step(); clr = 1'b0;
        chk(seen1, 1'b0, "R9 clear beats word-1 match");
        step();
        chk(seen1, 1'b1, "R9 match after clear released");
        pins = PAT_B; start = 1'b1; step(); start = 1'b0;
        chk(seen1, 1'b0, "R9 start clears seen1");
        chk(seen2, 1'b0, "R9 start beats word-2 match");
        chk(trig,  1'b0, "R9 start suppresses trig");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_and_match();
        t_order();
        t_same_cycle();
        t_trig_disabled();
        t_enables();
        t_clear_priority();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule